// File: doc/BRIEF.md
# ModR/M Operand Selector Decoder

This block sits in an instruction decode stage. On a one-cycle load strobe it takes an opcode byte together with the addressing byte that follows it. The addressing byte carries three fields: a two-bit mode field, a three-bit register field and a three-bit register-or-memory field. The block turns these into two 5-bit internal operand codes, called M and N. It holds those codes, along with a handful of mode flags, until the next strobe.

N always names the register chosen by the register field. M names the register chosen by the register-or-memory field when the mode field is 11. When the mode field is any other value, M names the memory operand register instead. Opcode bit 0 picks byte or word registers. Opcode bit 1 selects direction: when it is set, the two codes trade places at the output port. The swap happens on read only; the stored codes are left as decoded. The block also reports how many displacement bytes follow the addressing byte, so that the fetch logic can consume them. Address arithmetic and ALU work belong to other blocks.

Top module: `modrm_opnd_decoder`

## Requirements
- R1: After a synchronous reset, sel_m and sel_n both read the constant-zero code 5'h12. The flags is_mem, is_word and to_reg are 0, and disp_len is 0.
- R2: With mode field bits[7:6] = 11 and opcode bit 0 = 1, the register field bits[5:3] gives N = {2'b00, reg} and the field bits[2:0] gives M = {2'b00, rm}. Word codes 0 to 7 are AX, CX, DX, BX, SP, BP, SI, DI.
- R3: With opcode bit 0 = 0, register codes are {2'b01, field}, which is 5'h08 to 5'h0F for AL, CL, DL, BL, AH, CH, DH, BH. is_word reflects opcode bit 0.
- R4: With a mode field other than 11, is_mem is 1 and the stored M code is the memory operand code 5'h10, for either width. N still follows the register field.
- R5: With opcode bit 1 = 1, sel_m returns the stored N code and sel_n returns the stored M code. With opcode bit 1 = 0 the codes appear unswapped. to_reg reflects opcode bit 1.
- R6: While load is 0, all outputs hold their values, whatever the opcode and addressing byte inputs do.
- R7: disp_len is 1 for mode 01. It is 2 for mode 10, and also for mode 00 when the field bits[2:0] = 110 (fixed address). It is 0 for any other mode 00 byte and for mode 11.
- R8: Every output takes its new value on the first rising clock edge at which load is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for opcode and addressing byte |
| opcode | input | 8 | Opcode byte; bit 1 direction, bit 0 width |
| modrm | input | 8 | Addressing byte: mode[7:6], reg[5:3], rm[2:0] |
| sel_m | output | 5 | M operand code, after direction swap |
| sel_n | output | 5 | N operand code, after direction swap |
| is_mem | output | 1 | A memory mode is in use |
| is_word | output | 1 | Word-sized operation |
| to_reg | output | 1 | Result goes to the register named by the register field |
| disp_len | output | 2 | Number of displacement bytes that follow (0, 1 or 2) |

## Verification
Every result is registered exactly once. The codes, the flags and the displacement length are all due on the rising edge that samples load high, and the read-side swap adds no further cycle. The bench changes inputs on the falling edge, pulses load for one cycle, and samples on the next falling edge. That edge lies half a period after the capture edge, so each check falls in the first cycle the new value is valid. For the hold cases, the bench disturbs the inputs over several cycles with load low and samples after each one.

// File: rtl/modrm_pkg.sv
package modrm_pkg;
  localparam int SEL_W  = 3;
  localparam int CODE_W = 5;

  typedef logic [CODE_W-1:0] opnd_code_t;

  localparam logic [1:0] WORD_BANK = 2'b00;
  localparam logic [1:0] BYTE_BANK = 2'b01;
  localparam opnd_code_t OPR_CODE  = 5'h10;
  localparam opnd_code_t SUM_CODE  = 5'h11;
  localparam opnd_code_t ZERO_CODE = 5'h12;

  localparam logic [1:0]       MODE_REG   = 2'b11;
  localparam logic [SEL_W-1:0] RM_FIXED   = 3'b110;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } disp_len_t;

  typedef struct packed {
    logic [1:0]       mode;
    logic [SEL_W-1:0] reg_f;
    logic [SEL_W-1:0] rm_f;
    logic             to_reg;
    logic             wide;
  } fields_t;
endpackage

// File: rtl/modrm_field_split.sv
module modrm_field_split
  import modrm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] opcode_i,
  input  logic [BYTE_W-1:0] modrm_i,
  output fields_t           fld_o,
  output logic              mem_o,
  output disp_len_t         disp_o
);
  localparam int RM_LSB   = 0;
  localparam int REG_LSB  = SEL_W;
  localparam int MODE_LSB = 2 * SEL_W;

  always_comb begin
    fld_o.mode   = modrm_i[MODE_LSB +: 2];
    fld_o.reg_f  = modrm_i[REG_LSB +: SEL_W];
    fld_o.rm_f   = modrm_i[RM_LSB +: SEL_W];
    fld_o.to_reg = opcode_i[1];
    fld_o.wide   = opcode_i[0];
  end

  assign mem_o = (fld_o.mode != MODE_REG);

  always_comb begin
    unique case (fld_o.mode)
      2'b01:   disp_o = DISP_BYTE;
      2'b10:   disp_o = DISP_WORD;
      2'b00:   disp_o = (fld_o.rm_f == RM_FIXED) ? DISP_WORD : DISP_NONE;
      default: disp_o = DISP_NONE;
    endcase
  end
endmodule

// File: rtl/modrm_code_map.sv
module modrm_code_map
  import modrm_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wide_i,
  input  logic             force_opr_i,
  output opnd_code_t       code_o
);
  always_comb begin
    if (force_opr_i)
      code_o = OPR_CODE;
    else if (wide_i)
      code_o = {WORD_BANK, sel_i};
    else
      code_o = {BYTE_BANK, sel_i};
  end
endmodule

// File: rtl/modrm_opnd_hold.sv
module modrm_opnd_hold
  import modrm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  opnd_code_t m_in,
  input  opnd_code_t n_in,
  input  logic       mem_in,
  input  logic       wide_in,
  input  logic       to_reg_in,
  input  disp_len_t  disp_in,
  output opnd_code_t m_out,
  output opnd_code_t n_out,
  output logic       mem_out,
  output logic       wide_out,
  output logic       to_reg_out,
  output disp_len_t  disp_out
);
  opnd_code_t m_q, n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q        <= ZERO_CODE;
      n_q        <= ZERO_CODE;
      mem_out    <= 1'b0;
      wide_out   <= 1'b0;
      to_reg_out <= 1'b0;
      disp_out   <= DISP_NONE;
    end else if (load_i) begin
      m_q        <= m_in;
      n_q        <= n_in;
      mem_out    <= mem_in;
      wide_out   <= wide_in;
      to_reg_out <= to_reg_in;
      disp_out   <= disp_in;
    end
  end

  // Direction swap is applied at the read port; stored codes stay as decoded.
  assign m_out = to_reg_out ? n_q : m_q;
  assign n_out = to_reg_out ? m_q : n_q;

  // R6: no strobe, no change
  a_r6_hold_codes: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(m_out) && $stable(n_out) && $stable(disp_out)));

  // R5: the output pair is the stored pair, possibly exchanged
  a_r5_swap_pair: assert property (@(posedge clk) disable iff (rst)
    to_reg_out |-> (m_out == n_q && n_out == m_q));

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (m_out == ZERO_CODE && n_out == ZERO_CODE && !mem_out
                    && disp_out == DISP_NONE));
endmodule

// File: rtl/modrm_opnd_decoder.sv
module modrm_opnd_decoder
  import modrm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] modrm,
  output logic [CODE_W-1:0] sel_m,
  output logic [CODE_W-1:0] sel_n,
  output logic              is_mem,
  output logic              is_word,
  output logic              to_reg,
  output logic [1:0]        disp_len
);
  localparam int NUM_SEL = 2;   // index 0 = M (rm field), 1 = N (reg field)

  fields_t    fld;
  logic       mem_d;
  disp_len_t  disp_d, disp_q;
  opnd_code_t code_d [NUM_SEL];

  modrm_field_split #(.BYTE_W(BYTE_W)) u_split (
    .opcode_i (opcode),
    .modrm_i  (modrm),
    .fld_o    (fld),
    .mem_o    (mem_d),
    .disp_o   (disp_d)
  );

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_map
    modrm_code_map u_map (
      .sel_i       ((i == 0) ? fld.rm_f : fld.reg_f),
      .wide_i      (fld.wide),
      .force_opr_i ((i == 0) ? mem_d : 1'b0),
      .code_o      (code_d[i])
    );
  end

  modrm_opnd_hold u_hold (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .m_in       (code_d[0]),
    .n_in       (code_d[1]),
    .mem_in     (mem_d),
    .wide_in    (fld.wide),
    .to_reg_in  (fld.to_reg),
    .disp_in    (disp_d),
    .m_out      (sel_m),
    .n_out      (sel_n),
    .mem_out    (is_mem),
    .wide_out   (is_word),
    .to_reg_out (to_reg),
    .disp_out   (disp_q)
  );

  assign disp_len = disp_q;

  // R4: memory mode puts the memory operand code on the non-register side
  a_r4_mem_opr: assert property (@(posedge clk) disable iff (rst)
    (is_mem && !to_reg) |-> sel_m == OPR_CODE);
  a_r4_mem_opr_swapped: assert property (@(posedge clk) disable iff (rst)
    (is_mem && to_reg) |-> sel_n == OPR_CODE);

  // R7: register-register mode never carries a displacement
  a_r7_reg_no_disp: assert property (@(posedge clk) disable iff (rst)
    !is_mem |-> disp_len == 2'd0);

  // R8: a strobe with mode 11 leaves register mode one edge later
  a_r8_reg_mode_next: assert property (@(posedge clk) disable iff (rst)
    (load && modrm[7:6] == 2'b11) |=> !is_mem);
endmodule

// File: tb/modrm_opnd_decoder_test.sv
module modrm_opnd_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] modrm = 8'h00;
  logic [4:0] sel_m, sel_n;
  logic       is_mem, is_word, to_reg;
  logic [1:0] disp_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  modrm_opnd_decoder uut (
    .clk(clk), .rst(rst), .load(load), .opcode(opcode), .modrm(modrm),
    .sel_m(sel_m), .sel_n(sel_n), .is_mem(is_mem), .is_word(is_word),
    .to_reg(to_reg), .disp_len(disp_len)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [4:0] reg_code(input logic [2:0] f, input logic w);
    return w ? {2'b00, f} : {2'b01, f};
  endfunction

  // Load on one falling edge; the capture edge follows; sample at next falling edge
  task automatic strobe(input logic [7:0] op, input logic [7:0] mr);
    @(negedge clk);
    load = 1'b1; opcode = op; modrm = mr;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic expect_all(input string req, input logic [7:0] op, input logic [7:0] mr);
    logic [4:0] m_raw, n_raw, em, en;
    logic       mem;
    logic [1:0] dl;
    mem   = (mr[7:6] != 2'b11);
    n_raw = reg_code(mr[5:3], op[0]);
    m_raw = mem ? 5'h10 : reg_code(mr[2:0], op[0]);
    em = op[1] ? n_raw : m_raw;
    en = op[1] ? m_raw : n_raw;
    case (mr[7:6])
      2'b01:   dl = 2'd1;
      2'b10:   dl = 2'd2;
      2'b00:   dl = (mr[2:0] == 3'b110) ? 2'd2 : 2'd0;
      default: dl = 2'd0;
    endcase
    check(req, "sel_m", sel_m, em);
    check(req, "sel_n", sel_n, en);
    check(req, "is_mem", is_mem, mem);
    check(req, "is_word", is_word, op[0]);
    check(req, "to_reg", to_reg, op[1]);
    check(req, "disp_len", disp_len, dl);
  endtask

  task automatic t_r1_reset();
    @(negedge clk);
    check("R1", "sel_m", sel_m, 5'h12);
    check("R1", "sel_n", sel_n, 5'h12);
    check("R1", "is_mem", is_mem, 0);
    check("R1", "is_word", is_word, 0);
    check("R1", "to_reg", to_reg, 0);
    check("R1", "disp_len", disp_len, 0);
  endtask

  task automatic t_r2_word_regs();
    strobe(8'h01, 8'hC3);           // reg=000 AX, rm=011 BX
    check("R2", "sel_m BX", sel_m, 5'h03);
    check("R2", "sel_n AX", sel_n, 5'h00);
    for (int r = 0; r < 8; r++) begin
      strobe(8'h01, {2'b11, 3'(r), 3'(7 - r)});
      expect_all("R2", 8'h01, {2'b11, 3'(r), 3'(7 - r)});
    end
  endtask

  task automatic t_r3_byte_regs();
    strobe(8'h00, 8'hCF);           // reg=001 CL, rm=111 BH
    check("R3", "sel_m BH", sel_m, 5'h0F);
    check("R3", "sel_n CL", sel_n, 5'h09);
    check("R3", "is_word", is_word, 0);
    strobe(8'h00, 8'hE4);
    expect_all("R3", 8'h00, 8'hE4);
  endtask

  task automatic t_r4_memory();
    strobe(8'h01, 8'h04);           // mode 00, reg AX, rm [SI]
    check("R4", "sel_m OPR", sel_m, 5'h10);
    check("R4", "sel_n AX", sel_n, 5'h00);
    check("R4", "is_mem", is_mem, 1);
    strobe(8'h00, 8'h6A);           // mode 01, byte, reg=101 CH
    check("R4", "sel_m OPR byte", sel_m, 5'h10);
    check("R4", "sel_n CH", sel_n, 5'h0D);
  endtask

  task automatic t_r5_swap();
    strobe(8'h03, 8'h04);           // D=1, memory source
    check("R5", "sel_m AX", sel_m, 5'h00);
    check("R5", "sel_n OPR", sel_n, 5'h10);
    check("R5", "to_reg", to_reg, 1);
    strobe(8'h02, 8'hD9);           // D=1, byte, reg=011 BL, rm=001 CL
    check("R5", "sel_m BL", sel_m, 5'h0B);
    check("R5", "sel_n CL", sel_n, 5'h09);
    for (int k = 0; k < 4; k++) begin
      strobe({6'b0, 2'(k)}, 8'h9D);
      expect_all("R5", {6'b0, 2'(k)}, 8'h9D);
    end
  endtask

  task automatic t_r6_hold();
    strobe(8'h01, 8'hDA);
    for (int k = 0; k < 4; k++) begin
      opcode = 8'hA6 ^ 8'(k); modrm = 8'h45 + 8'(k * 37);
      @(negedge clk);
      expect_all("R6", 8'h01, 8'hDA);
    end
  endtask

  task automatic t_r7_disp();
    strobe(8'h01, 8'h47); check("R7", "mode01", disp_len, 1);
    strobe(8'h01, 8'h84); check("R7", "mode10", disp_len, 2);
    strobe(8'h01, 8'h06); check("R7", "fixed addr", disp_len, 2);
    check("R7", "fixed addr mem", is_mem, 1);
    strobe(8'h01, 8'h07); check("R7", "mode00", disp_len, 0);
    strobe(8'h01, 8'hC6); check("R7", "mode11 rm110", disp_len, 0);
  endtask

  task automatic t_r8_timing();
    strobe(8'h01, 8'hC0);
    @(negedge clk);
    opcode = 8'h02; modrm = 8'h1E; load = 1'b1;
    @(posedge clk); #1;
    load = 1'b0;
    check("R8", "sel_m one edge", sel_m, 5'h0B);
    check("R8", "sel_n one edge", sel_n, 5'h10);
    check("R8", "disp_len one edge", disp_len, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_r1_reset();
    t_r2_word_regs();
    t_r3_byte_regs();
    t_r4_memory();
    t_r5_swap();
    t_r6_hold();
    t_r7_disp();
    t_r8_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule